// File: doc/BRIEF.md
# External Data-Memory Access Stretch Sequencer

This block times one read or write cycle on an external data-memory bus. A processor core raises a one-clock start request with the direction, the address, the write data, a flag that tells whether the access misses the currently open address page, and a 3-bit stretch code. The sequencer then walks through four phases: an address-latch pulse, a setup gap, the read or write strobe, and a hold gap. It raises a one-clock completion pulse at the end. Every phase is measured in system clocks. One basic memory cycle and one stretch cycle are each `CYC_CLKS` clocks long (4 by default).

Codes 0 to 3 add 0 to 3 stretch cycles. Code 1 spends part of its added cycle on wider setup and hold, so the strobe grows by less than a full cycle. Codes 4 to 7 serve slow devices. They add 7, 8, 9 or 10 stretch cycles. Of these, two cycles widen setup and one widens hold. In this group a page miss also widens the address-latch pulse by one stretch cycle, and that cycle is taken out of setup. Read data is captured on the edge that closes the read strobe.

Top module: `ext_mem_stretch_seq`

## Requirements
- R1: While reset is asserted: ale=0, rdN=1, wrN=1, addrOe=0, dataOe=0, capture=0, done=0.
- R2: With code 0 an access takes 8 clocks from the first ale cycle to the last hold cycle: ale 2, setup 1, strobe 4, hold 1. Done follows in the 9th clock.
- R3: With codes 1, 2 and 3 the phase lengths are ale 2, setup 2, strobe 4*code+2 and hold 2. This gives 12, 16 and 20 clocks.
- R4: With codes 4 to 7 and pageMiss=0, n is code+3. The phase lengths are then ale 2, setup 9, strobe 4*n-8 and hold 5, for a total of 8+4*n clocks.
- R5: With codes 4 to 7 and pageMiss=1, ale lasts 6 clocks and setup 5, and the total is unchanged. For codes 0 to 3, pageMiss has no effect.
- R6: isRead=1 selects a read and drives only rdN low during the strobe phase. isRead=0 drives only wrN low. The two are never low together.
- R7: On a read, capture is high only in the last strobe clock, and rdDataOut then holds the rdDataIn value sampled at the edge that closes that clock.
- R8: On a write, dataOe is high from the first setup clock through the last hold clock, and wrDataOut carries the write data. dataOe is low on reads and during done.
- R9: addrOe is high from the first ale clock through the last hold clock. addrOut holds the address sampled when start was accepted.
- R10: A start seen while an access is in its ale, setup, strobe or hold phase is ignored. The stretch code, direction, page flag, address and data are sampled only at acceptance.
- R11: done is high for exactly one clock. A start seen in that done clock is accepted, and ale rises on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Access request, sampled each clock |
| isRead | input | 1 | 1 = read access, 0 = write access |
| pageMiss | input | 1 | Access misses the open address page |
| stretchCode | input | 3 | Stretch setting 0..7 |
| addrIn | input | ADDR_W | Access address |
| wrDataIn | input | DATA_W | Write data |
| rdDataIn | input | DATA_W | Data returned by the external device |
| ale | output | 1 | Address-latch pulse |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| addrOe | output | 1 | Address-output enable |
| dataOe | output | 1 | Write data-output enable |
| capture | output | 1 | Read data-capture strobe |
| addrOut | output | ADDR_W | Latched address |
| wrDataOut | output | DATA_W | Latched write data |
| rdDataOut | output | DATA_W | Captured read data |
| done | output | 1 | One-clock completion pulse |

## Verification
A wrong phase counter or a wrong length table changes the clock in which a strobe edge or the done pulse appears. That shift shows within a clock of the faulty phase boundary. A wrong latched direction or code shows up in the first strobe or setup clock as the wrong strobe pin, or as dataOe in the wrong state. A bad acceptance rule shows as an ale pulse where none should start, or as a missing ale pulse right after done. Comparing every port with a reference model on every clock catches each of these in the clock where it first diverges.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
  } dpStrobe_t;

  typedef struct packed {
    int unsigned aleLen;
    int unsigned setupLen;
    int unsigned strobeLen;
    int unsigned holdLen;
  } phaseLen_t;

  // number of stretch cycles for a code: linear up to 3, then offset by 3
  function automatic int unsigned stretchCycles(input logic [2:0] code);
    return (code < 3'd4) ? int'(code) : int'(code) + 3;
  endfunction

  // clock counts of each phase; cyc = clocks per memory cycle (multiple of 4)
  function automatic phaseLen_t phaseLens(input logic [2:0] code,
                                          input logic miss,
                                          input int unsigned cyc);
    phaseLen_t   r;
    int unsigned n;
    n = stretchCycles(code);
    if (code == 3'd0) begin
      r.aleLen    = cyc / 2;
      r.setupLen  = cyc / 4;
      r.strobeLen = cyc;
      r.holdLen   = cyc / 4;
    end else if (code < 3'd4) begin
      r.aleLen    = cyc / 2;
      r.setupLen  = cyc / 2;
      r.strobeLen = cyc + n * cyc - cyc / 2;
      r.holdLen   = cyc / 2;
    end else begin
      r.aleLen    = cyc / 2 + (miss ? cyc : 0);
      r.setupLen  = cyc / 4 + 2 * cyc - (miss ? cyc : 0);
      r.strobeLen = cyc + n * cyc - 3 * cyc;
      r.holdLen   = cyc / 4 + cyc;
    end
    return r;
  endfunction

endpackage

// File: rtl/stretch_ctrl.sv
module stretch_ctrl
  import stretch_pkg::*;
#(
  parameter int CYC_CLKS = 4,
  parameter int CNT_W    = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  input  logic        pageMiss,
  input  logic [2:0]  stretchCode,
  output dpStrobe_t   dpStb,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic        addrOe,
  output logic        dataOe,
  output logic        capture,
  output logic        done
);

  phase_e             phase;
  logic [CNT_W-1:0]   cnt;
  logic [2:0]         codeQ;
  logic               missQ;
  logic               readQ;
  logic               accept;
  logic               lastTick;
  phaseLen_t          lensNow;
  phaseLen_t          lensQ;

  always_comb begin
    lensNow  = phaseLens(stretchCode, pageMiss, CYC_CLKS);
    lensQ    = phaseLens(codeQ, missQ, CYC_CLKS);
    accept   = start && (phase == PH_IDLE || phase == PH_DONE);
    lastTick = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      codeQ <= '0;
      missQ <= 1'b0;
      readQ <= 1'b0;
    end else if (accept) begin
      phase <= PH_ALE;
      cnt   <= CNT_W'(lensNow.aleLen - 1);
      codeQ <= stretchCode;
      missQ <= pageMiss;
      readQ <= isRead;
    end else begin
      unique case (phase)
        PH_ALE: begin
          if (lastTick) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(lensQ.setupLen - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(lensQ.strobeLen - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_STROBE: begin
          if (lastTick) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(lensQ.holdLen - 1);
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (lastTick) phase <= PH_DONE;
          else cnt <= cnt - 1'b1;
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ale     = (phase == PH_ALE);
    rdN     = !((phase == PH_STROBE) && readQ);
    wrN     = !((phase == PH_STROBE) && !readQ);
    addrOe  = (phase == PH_ALE) || (phase == PH_SETUP) ||
              (phase == PH_STROBE) || (phase == PH_HOLD);
    dataOe  = !readQ && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                         (phase == PH_HOLD));
    capture = (phase == PH_STROBE) && readQ && lastTick;
    done    = (phase == PH_DONE);
    dpStb.load    = accept;
    dpStb.capture = capture;
  end

endmodule

// File: rtl/stretch_dp.sv
module stretch_dp
  import stretch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrDataIn,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] wrDataOut,
  output logic [DATA_W-1:0] rdDataOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut   <= '0;
      wrDataOut <= '0;
    end else if (dpStb.load) begin
      addrOut   <= addrIn;
      wrDataOut <= wrDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdDataOut <= '0;
    else if (dpStb.capture) rdDataOut <= rdDataIn;
  end

endmodule

// File: rtl/ext_mem_stretch_seq.sv
module ext_mem_stretch_seq
  import stretch_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CYC_CLKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isRead,
  input  logic              pageMiss,
  input  logic [2:0]        stretchCode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wrDataIn,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              addrOe,
  output logic              dataOe,
  output logic              capture,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] wrDataOut,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              done
);

  // longest phase is the code-7 strobe: 8 cycles
  localparam int CNT_W = $clog2(12 * CYC_CLKS);

  dpStrobe_t dpStb;

  stretch_ctrl #(.CYC_CLKS(CYC_CLKS), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .pageMiss(pageMiss), .stretchCode(stretchCode), .dpStb(dpStb),
    .ale(ale), .rdN(rdN), .wrN(wrN), .addrOe(addrOe), .dataOe(dataOe),
    .capture(capture), .done(done)
  );

  stretch_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .addrIn(addrIn),
    .wrDataIn(wrDataIn), .rdDataIn(rdDataIn), .addrOut(addrOut),
    .wrDataOut(wrDataOut), .rdDataOut(rdDataOut)
  );

endmodule

// File: rtl/ext_mem_stretch_chk.sv
module ext_mem_stretch_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              ale,
  input logic              rdN,
  input logic              wrN,
  input logic              addrOe,
  input logic              dataOe,
  input logic              capture,
  input logic [ADDR_W-1:0] addrOut,
  input logic              done
);

  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  p_ale_no_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));

  p_cap_in_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    capture |-> !rdN);

  p_cap_then_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    capture |=> rdN);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!dataOe && rdN && wrN && !ale));

  p_wr_has_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> dataOe);

  p_strobe_has_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN || ale) |-> addrOe);

  p_addr_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addrOe && $past(addrOe)) |-> $stable(addrOut));

endmodule

bind ext_mem_stretch_seq ext_mem_stretch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN),
  .addrOe(addrOe), .dataOe(dataOe), .capture(capture),
  .addrOut(addrOut), .done(done)
);

// File: tb/ext_mem_stretch_seq_tb.sv
module ext_mem_stretch_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isRead = 1'b0;
  logic        pageMiss = 1'b0;
  logic [2:0]  stretchCode = 3'd0;
  logic [15:0] addrIn = '0;
  logic [7:0]  wrDataIn = '0;
  logic [7:0]  rdDataIn = '0;
  logic        ale, rdN, wrN, addrOe, dataOe, capture, done;
  logic [15:0] addrOut;
  logic [7:0]  wrDataOut, rdDataOut;

  int checks = 0;
  int fails  = 0;
  int curTag = 2;
  bit timedOut = 0;

  always #10 clk = ~clk;  // 50 MHz

  ext_mem_stretch_seq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .pageMiss(pageMiss), .stretchCode(stretchCode), .addrIn(addrIn),
    .wrDataIn(wrDataIn), .rdDataIn(rdDataIn), .ale(ale), .rdN(rdN),
    .wrN(wrN), .addrOe(addrOe), .dataOe(dataOe), .capture(capture),
    .addrOut(addrOut), .wrDataOut(wrDataOut), .rdDataOut(rdDataOut),
    .done(done)
  );

  typedef struct {
    logic        ale, rdN, wrN, aOe, dOe, cap, dn;
    bit          rdChk;
    logic [15:0] a;
    logic [7:0]  wd, rd;
    int          tag;
  } exp_t;

  exp_t q[$];

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // phase lengths written from the requirements for 4-clock cycles
  // R2 code 0, R3 codes 1-3, R4/R5 codes 4-7
  function automatic void lens(input logic [2:0] code, input bit miss,
                               output int a, output int s, output int st, output int h);
    int n;
    if (code == 0) begin a = 2; s = 1; st = 4; h = 1; end
    else if (code < 4) begin a = 2; s = 2; st = 4 * code + 2; h = 2; end
    else begin
      n = code + 3;
      a = miss ? 6 : 2; s = miss ? 5 : 9; st = 4 * n - 8; h = 5;
    end
  endfunction

  function automatic exp_t mk(input int ph, input bit r, input bit last,
                              input logic [15:0] a, input logic [7:0] wd,
                              input logic [7:0] rd, input int tag);
    exp_t e;
    e.ale = (ph == 0);
    e.rdN = !(ph == 2 && r);
    e.wrN = !(ph == 2 && !r);
    e.aOe = (ph != 4);
    e.dOe = !r && (ph == 1 || ph == 2 || ph == 3);
    e.cap = (ph == 2) && r && last;
    e.dn  = (ph == 4);
    e.rdChk = r && (ph == 4);
    e.a = a; e.wd = wd; e.rd = rd; e.tag = tag;
    return e;
  endfunction

  // reference: accept when nothing is pending (idle or last cycle was done)
  always @(posedge clk) begin
    if (rstN && q.size() == 0 && start) begin
      int a, s, st, h;
      lens(stretchCode, pageMiss, a, s, st, h);
      for (int i = 0; i < a; i++)  q.push_back(mk(0, isRead, 0, addrIn, wrDataIn, rdDataIn, curTag));
      for (int i = 0; i < s; i++)  q.push_back(mk(1, isRead, 0, addrIn, wrDataIn, rdDataIn, curTag));
      for (int i = 0; i < st; i++) q.push_back(mk(2, isRead, i == st - 1, addrIn, wrDataIn, rdDataIn, curTag));
      for (int i = 0; i < h; i++)  q.push_back(mk(3, isRead, 0, addrIn, wrDataIn, rdDataIn, curTag));
      q.push_back(mk(4, isRead, 0, addrIn, wrDataIn, rdDataIn, curTag));
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e = mk(5, 1, 0, '0, '0, '0, 1);
        e.aOe = 0;
      end
      chk(ale == e.ale, e.tag, "ale", 32'(ale), 32'(e.ale));
      chk(done == e.dn, e.tag, "done", 32'(done), 32'(e.dn));
      chk(rdN == e.rdN && wrN == e.wrN, 6, "rdN,wrN", {rdN, wrN}, {e.rdN, e.wrN});  // R6
      chk(capture == e.cap, 7, "capture", 32'(capture), 32'(e.cap));                 // R7
      chk(dataOe == e.dOe, 8, "dataOe", 32'(dataOe), 32'(e.dOe));                    // R8
      chk(addrOe == e.aOe, 9, "addrOe", 32'(addrOe), 32'(e.aOe));                    // R9
      if (e.aOe) chk(addrOut == e.a, 9, "addrOut", 32'(addrOut), 32'(e.a));
      if (e.dOe) chk(wrDataOut == e.wd, 8, "wrDataOut", 32'(wrDataOut), 32'(e.wd));
      if (e.rdChk) chk(rdDataOut == e.rd, 7, "rdDataOut", 32'(rdDataOut), 32'(e.rd));
    end
  end

  task automatic access(input bit rd, input bit miss, input logic [2:0] code,
                        input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] rv, input int tag);
    int n, a_, s_, st_, h_;
    @(negedge clk);
    curTag = tag; isRead = rd; pageMiss = miss; stretchCode = code;
    addrIn = a; wrDataIn = wd; rdDataIn = rv; start = 1;
    @(negedge clk);
    start = 0; n = 1;
    while (!done && n < 100) begin @(negedge clk); n++; end
    lens(code, miss, a_, s_, st_, h_);
    chk(n == a_ + s_ + st_ + h_ + 1, tag, "cycles to done", 32'(n), 32'(a_ + s_ + st_ + h_ + 1));
  endtask

  task automatic runTests();
    int n;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!ale && rdN && wrN && !addrOe && !dataOe && !capture && !done, 1,
        "reset outputs", {ale, rdN, wrN, addrOe, dataOe, capture, done}, 7'b0110000);
    @(negedge clk); rstN = 1;
    repeat (2) @(negedge clk);

    for (int c = 0; c < 8; c++) begin
      int tg;
      tg = (c == 0) ? 2 : (c < 4 ? 3 : 4);  // R2 / R3 / R4 hit accesses
      access(1, 0, 3'(c), 16'h1000 + 16'(c), 8'h00, 8'hA0 + 8'(c), tg);
      access(0, 0, 3'(c), 16'h2000 + 16'(c), 8'h50 + 8'(c), 8'h00, tg);
    end
    for (int c = 0; c < 8; c++)  // R5: page miss, only codes 4-7 change
      access(c[0], 1, 3'(c), 16'hC3C0 + 16'(c), 8'h3C, 8'h5A + 8'(c), 5);

    // R10: extra starts while busy with a different code are ignored
    @(negedge clk);
    curTag = 10; isRead = 1; pageMiss = 0; stretchCode = 3'd1;
    addrIn = 16'hBEEF; rdDataIn = 8'h77; start = 1;
    @(negedge clk);
    start = 0; n = 1;
    stretchCode = 3'd7; isRead = 0; addrIn = 16'h0BAD;
    for (int i = 0; i < 5; i++) begin start = 1; @(negedge clk); n++; end
    start = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(n == 13, 10, "cycles to done with busy starts", 32'(n), 32'd13);

    // R11: start held across done, next access begins right after done
    @(negedge clk);
    curTag = 11; isRead = 0; pageMiss = 0; stretchCode = 3'd0;
    addrIn = 16'h1111; wrDataIn = 8'h99; start = 1;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(ale == 1'b1, 11, "ale after done", 32'(ale), 32'd1);
    start = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      runTests();
      begin repeat (20000) @(posedge clk); timedOut = 1; end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule